// File: doc/BRIEF.md
# Isolatable Direct-Mapped Cache Controller

This controller sits between a 32-bit processor and a single-word main-memory port. It holds two direct-mapped arrays, an instruction array and a data array. Each array keeps one tag, one valid flag and one dirty flag per line. A request carries a side (instruction or data), a direction, a byte count, an address and lane-positioned write data. A hit read returns the whole 32-bit word that holds the access. A miss evicts a dirty victim by writing it back, refills the line one word per beat, and then completes the access. Every store that is not isolated is also written through to memory.

Two processor status inputs change how requests are served. The swap input makes each side use the other side's array. The isolate input cuts the data side off from memory: isolated reads return whatever the array holds, and isolated stores update the array and invalidate the line. A miss status output reports the result of the latest data-side read lookup. Accesses marked uncached, and accesses longer than four bytes, go straight to memory as a single beat.

The processor presents a request while `stall` is low. `stall` stays high from the cycle after acceptance until the response pulse. The memory port uses a valid/ready handshake. Read data is taken in the cycle in which valid and ready are both high.

Top module: `iso_dm_cache`

## Requirements
- R1: A request with `req_uncached` high or `req_len` above 4 causes exactly one memory beat at the word-aligned address and leaves the arrays and `miss_flag` unchanged. A read returns `mem_rdata`. A write uses all four strobes when `req_len` is above 4, and the R13 lanes otherwise. The response comes 3 cycles after acceptance.
- R2: The array used is the request side XOR `swap_arrays`: 0 selects the instruction array and 1 selects the data array. `req_data_side` is 1 for data.
- R3: The line index is address bits [log2(CACHE_BYTES)-1 : log2(LINE_BYTES)]. The stored tag is address bits [ADDR_W-1 : log2(CACHE_BYTES)].
- R4: A hit needs the line valid and the stored tag equal to the request tag. A hit read responds 2 cycles after acceptance with no memory beat.
- R5: On every data-side cached read, `miss_flag` is set to the inverse of the hit result. Writes, instruction requests and bypassed requests leave it unchanged.
- R6: While `isolate_data` is high at acceptance, a data-side cached request issues no memory beat and responds after 2 cycles. A read returns the array word without regard to tag or valid.
- R7: A miss on a line that is invalid or clean refills LINE_BYTES/4 words in ascending order from the line base. It then marks the line valid and clean with the new tag, and completes the access as a hit.
- R8: A miss on a line that is valid and dirty first writes its LINE_BYTES/4 words back to the old tag's address, before the refill.
- R9: A store sets the line's dirty flag only if at least one strobed byte differs from the cached byte.
- R10: An isolated store writes its bytes into the array and clears the line's valid and dirty flags, so the next non-isolated access to that line misses.
- R11: A non-isolated cached store issues exactly one memory write beat, after any refill, carrying the request's lanes. It responds one cycle after its cache update.
- R12: Reset clears every valid and dirty flag and drives `stall`, `resp_valid` and `miss_flag` low.
- R13: Byte lanes run from addr[1:0] to addr[1:0]+len-1 and are clipped at lane 3. Write data is given in those lanes. Read data is the whole aligned word.
- R14: `stall` is high from the cycle after acceptance until the response cycle. In the response cycle it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (taken when stall is low) |
| req_data_side | input | 1 | 1 data side, 0 instruction side |
| req_write | input | 1 | 1 store, 0 load |
| req_uncached | input | 1 | Bypass the arrays |
| req_len | input | 3 | Byte count |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Lane-positioned store data |
| swap_arrays | input | 1 | Exchange the array roles |
| isolate_data | input | 1 | Cut the data side off from memory |
| stall | output | 1 | Controller busy |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load result word |
| miss_flag | output | 1 | Latest data-read lookup missed |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | Beat direction |
| mem_addr | output | ADDR_W | Word-aligned beat address |
| mem_wdata | output | 32 | Beat write data |
| mem_wstrb | output | 4 | Beat byte strobes |
| mem_rdata | input | 32 | Beat read data |

## Verification
With memory always ready, the response is due a fixed number of cycles after the acceptance edge. A hit load or an isolated access takes 2 cycles, and a bypass or a hit store takes 3. A miss adds LINE_BYTES/4+1 cycles, plus another LINE_BYTES/4 when the victim is dirty. `miss_flag` and the beat counts settle with the response. The bench computes this latency from a behavioural model of tags, flags and memory, counts falling edges from acceptance to the response pulse, and compares the count, the read and write beat totals, the data and the flag in that same sampling slot.

// File: rtl/idmc_pkg.sv
package idmc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOK   = 3'd1,
        ST_WBACK  = 3'd2,
        ST_FILL   = 3'd3,
        ST_WTHRU  = 3'd4,
        ST_BYPASS = 3'd5
    } idmc_state_e;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned MAX_CACHED_LEN = 4;
endpackage

// File: rtl/idmc_bank.sv
module idmc_bank #(
    parameter int WORDS  = 256,
    parameter int LINES  = 64,
    parameter int TAG_W  = 22,
    parameter int IDX_W  = 6,
    parameter int WIDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDX_W-1:0] rd_widx,
    output logic [31:0]       rd_word,
    input  logic [IDX_W-1:0]  rd_line,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic              rd_dirty,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_widx,
    input  logic [31:0]       wr_word,
    input  logic              meta_en,
    input  logic [IDX_W-1:0]  meta_line,
    input  logic [TAG_W-1:0]  meta_tag,
    input  logic              meta_valid,
    input  logic              meta_dirty
);
    logic [31:0]      words_q [WORDS];
    logic [TAG_W-1:0] tags_q  [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    assign rd_word  = words_q[rd_widx];
    assign rd_tag   = tags_q[rd_line];
    assign rd_valid = valid_q[rd_line];
    assign rd_dirty = dirty_q[rd_line];

    always_ff @(posedge clk) begin
        if (wr_en) words_q[wr_widx] <= wr_word;
        if (meta_en) tags_q[meta_line] <= meta_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (meta_en) begin
            valid_q[meta_line] <= meta_valid;
            dirty_q[meta_line] <= meta_dirty;
        end
    end
endmodule

// File: rtl/idmc_lanes.sv
module idmc_lanes (
    input  logic [1:0]  off,
    input  logic [2:0]  len,
    input  logic [31:0] old_word,
    input  logic [31:0] new_word,
    output logic [3:0]  strb,
    output logic [31:0] merged,
    output logic        differs
);
    logic [3:0] lane_diff;
    logic [3:0] end_pos;

    assign end_pos = {2'b00, off} + {1'b0, len};

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign strb[g] = ({2'b00, off} <= 4'(g)) && (end_pos > 4'(g));
        assign merged[8*g +: 8] = strb[g] ? new_word[8*g +: 8] : old_word[8*g +: 8];
        assign lane_diff[g] = strb[g] && (new_word[8*g +: 8] != old_word[8*g +: 8]);
    end

    assign differs = |lane_diff;
endmodule

// File: rtl/iso_dm_cache.sv
module iso_dm_cache
    import idmc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CACHE_BYTES = 1024,
    parameter int LINE_BYTES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_data_side,
    input  logic              req_write,
    input  logic              req_uncached,
    input  logic [2:0]        req_len,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              swap_arrays,
    input  logic              isolate_data,
    output logic              stall,
    output logic              resp_valid,
    output logic [31:0]       resp_rdata,
    output logic              miss_flag,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_wstrb,
    input  logic [31:0]       mem_rdata
);
    localparam int CB_L2  = $clog2(CACHE_BYTES);
    localparam int LB_L2  = $clog2(LINE_BYTES);
    localparam int LINES  = CACHE_BYTES / LINE_BYTES;
    localparam int WORDS  = CACHE_BYTES / WORD_BYTES;
    localparam int LW     = LINE_BYTES / WORD_BYTES;
    localparam int IDX_W  = CB_L2 - LB_L2;
    localparam int WIDX_W = CB_L2 - 2;
    localparam int BEAT_W = LB_L2 - 2;
    localparam int TAG_W  = ADDR_W - CB_L2;

    typedef struct packed {
        idmc_state_e        state;
        logic [BEAT_W-1:0]  beat;
        logic [ADDR_W-1:0]  addr;
        logic [31:0]        wdata;
        logic [2:0]         len;
        logic               wr;
        logic               dside;
        logic               arr;
        logic               iso;
        logic               byp;
        logic               retry;
        logic               miss;
        logic               rvalid;
        logic [31:0]        rdata;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [IDX_W-1:0]  line_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WIDX_W-1:0] req_widx, beat_widx, rd_widx;

    assign line_idx  = st_q.addr[CB_L2-1:LB_L2];
    assign req_tag   = st_q.addr[ADDR_W-1:CB_L2];
    assign req_widx  = st_q.addr[CB_L2-1:2];
    assign beat_widx = {line_idx, st_q.beat};
    assign rd_widx   = (st_q.state == ST_WBACK) ? beat_widx : req_widx;

    logic [31:0]      bk_word  [2];
    logic [TAG_W-1:0] bk_tag   [2];
    logic             bk_valid [2];
    logic             bk_dirty [2];

    logic              word_we;
    logic [WIDX_W-1:0] wr_widx;
    logic [31:0]       wr_word;
    logic              meta_we;
    logic [TAG_W-1:0]  meta_tag;
    logic              meta_valid;
    logic              meta_dirty;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        idmc_bank #(
            .WORDS (WORDS),
            .LINES (LINES),
            .TAG_W (TAG_W),
            .IDX_W (IDX_W),
            .WIDX_W(WIDX_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_widx   (rd_widx),
            .rd_word   (bk_word[g]),
            .rd_line   (line_idx),
            .rd_tag    (bk_tag[g]),
            .rd_valid  (bk_valid[g]),
            .rd_dirty  (bk_dirty[g]),
            .wr_en     (word_we && (st_q.arr == 1'(g))),
            .wr_widx   (wr_widx),
            .wr_word   (wr_word),
            .meta_en   (meta_we && (st_q.arr == 1'(g))),
            .meta_line (line_idx),
            .meta_tag  (meta_tag),
            .meta_valid(meta_valid),
            .meta_dirty(meta_dirty)
        );
    end

    logic [31:0]      cur_word;
    logic [TAG_W-1:0] cur_tag;
    logic             cur_valid, cur_dirty, hit;

    assign cur_word  = bk_word[st_q.arr];
    assign cur_tag   = bk_tag[st_q.arr];
    assign cur_valid = bk_valid[st_q.arr];
    assign cur_dirty = bk_dirty[st_q.arr];
    assign hit       = cur_valid && (cur_tag == req_tag);

    logic [3:0]  lane_strb;
    logic [31:0] lane_merged;
    logic        lane_differs;

    idmc_lanes u_lanes (
        .off     (st_q.addr[1:0]),
        .len     (st_q.len),
        .old_word(cur_word),
        .new_word(st_q.wdata),
        .strb    (lane_strb),
        .merged  (lane_merged),
        .differs (lane_differs)
    );

    logic beat_last, fire;
    assign beat_last = (st_q.beat == BEAT_W'(LW - 1));
    assign fire      = mem_valid && mem_ready;

    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = {st_q.addr[ADDR_W-1:2], 2'b00};
        mem_wdata = st_q.wdata;
        mem_wstrb = 4'h0;
        case (st_q.state)
            ST_WBACK: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {cur_tag, line_idx, st_q.beat, 2'b00};
                mem_wdata = cur_word;
                mem_wstrb = 4'hF;
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {req_tag, line_idx, st_q.beat, 2'b00};
            end
            ST_WTHRU: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wstrb = lane_strb;
            end
            ST_BYPASS: begin
                mem_valid = 1'b1;
                mem_write = st_q.wr;
                mem_wstrb = !st_q.wr ? 4'h0 :
                            (st_q.len > 3'(MAX_CACHED_LEN)) ? 4'hF : lane_strb;
            end
            default: ;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.rvalid = 1'b0;
        word_we    = 1'b0;
        wr_widx    = req_widx;
        wr_word    = lane_merged;
        meta_we    = 1'b0;
        meta_tag   = cur_tag;
        meta_valid = cur_valid;
        meta_dirty = cur_dirty;

        case (st_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.state = ST_LOOK;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.len   = req_len;
                    st_d.wr    = req_write;
                    st_d.dside = req_data_side;
                    st_d.arr   = req_data_side ^ swap_arrays;
                    st_d.iso   = req_data_side && isolate_data;
                    st_d.byp   = req_uncached || (req_len > 3'(MAX_CACHED_LEN));
                    st_d.retry = 1'b0;
                    st_d.beat  = '0;
                end
            end
            ST_LOOK: begin
                if (st_q.byp) begin
                    st_d.state = ST_BYPASS;
                end else begin
                    if (st_q.dside && !st_q.wr && !st_q.retry) st_d.miss = !hit;
                    if (st_q.iso) begin
                        if (st_q.wr) begin
                            word_we    = 1'b1;
                            meta_we    = 1'b1;
                            meta_valid = 1'b0;
                            meta_dirty = 1'b0;
                        end else begin
                            st_d.rdata = cur_word;
                        end
                        st_d.rvalid = 1'b1;
                        st_d.state  = ST_IDLE;
                    end else if (hit) begin
                        if (st_q.wr) begin
                            word_we    = 1'b1;
                            meta_we    = 1'b1;
                            meta_dirty = cur_dirty || lane_differs;
                            st_d.state = ST_WTHRU;
                        end else begin
                            st_d.rdata  = cur_word;
                            st_d.rvalid = 1'b1;
                            st_d.state  = ST_IDLE;
                        end
                    end else begin
                        st_d.beat  = '0;
                        st_d.state = (cur_valid && cur_dirty) ? ST_WBACK : ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                if (fire) begin
                    st_d.beat = st_q.beat + BEAT_W'(1);
                    if (beat_last) st_d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                wr_widx = beat_widx;
                wr_word = mem_rdata;
                word_we = fire;
                if (fire) begin
                    st_d.beat = st_q.beat + BEAT_W'(1);
                    if (beat_last) begin
                        meta_we    = 1'b1;
                        meta_tag   = req_tag;
                        meta_valid = 1'b1;
                        meta_dirty = 1'b0;
                        st_d.retry = 1'b1;
                        st_d.state = ST_LOOK;
                    end
                end
            end
            ST_WTHRU: begin
                if (fire) begin
                    st_d.rvalid = 1'b1;
                    st_d.state  = ST_IDLE;
                end
            end
            ST_BYPASS: begin
                if (fire) begin
                    if (!st_q.wr) st_d.rdata = mem_rdata;
                    st_d.rvalid = 1'b1;
                    st_d.state  = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall      = (st_q.state != ST_IDLE);
    assign resp_valid = st_q.rvalid;
    assign resp_rdata = st_q.rdata;
    assign miss_flag  = st_q.miss;
endmodule

// File: rtl/idmc_checker.sv
module idmc_checker
    import idmc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input idmc_state_e       state,
    input logic              iso,
    input logic              byp,
    input logic              stall,
    input logic              resp_valid,
    input logic              miss_flag,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr
);
    assert_resp_unstalled_R14: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !stall);

    assert_flag_moves_after_lookup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOOK) |=> $stable(miss_flag));

    assert_isolated_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && iso && !byp) |-> !mem_valid);

    assert_beat_aligned_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

    assert_beat_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

    assert_reset_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!stall && !resp_valid && !miss_flag));
endmodule

bind iso_dm_cache idmc_checker #(.ADDR_W(ADDR_W)) u_idmc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (st_q.state),
    .iso       (st_q.iso),
    .byp       (st_q.byp),
    .stall     (stall),
    .resp_valid(resp_valid),
    .miss_flag (miss_flag),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr)
);

// File: tb/test_iso_dm_cache.sv
`timescale 1ns/1ps
module test_iso_dm_cache;
    localparam int CB = 64;
    localparam int LB = 8;
    localparam int LW = LB / 4;
    localparam int NL = CB / LB;
    localparam int NW = CB / 4;
    localparam int MW = 256;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, req_valid, req_data_side, req_write, req_uncached;
    logic [2:0] req_len;
    logic [31:0] req_addr, req_wdata;
    logic swap_arrays, isolate_data;
    logic stall, resp_valid, miss_flag;
    logic [31:0] resp_rdata;
    logic mem_valid, mem_ready, mem_write;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0] mem_wstrb;

    iso_dm_cache #(.ADDR_W(32), .CACHE_BYTES(CB), .LINE_BYTES(LB)) i_iso_dm_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data_side(req_data_side),
        .req_write(req_write), .req_uncached(req_uncached), .req_len(req_len),
        .req_addr(req_addr), .req_wdata(req_wdata), .swap_arrays(swap_arrays),
        .isolate_data(isolate_data), .stall(stall), .resp_valid(resp_valid),
        .resp_rdata(resp_rdata), .miss_flag(miss_flag), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata)
    );

    logic [31:0] tb_mem  [MW];
    logic [31:0] ref_mem [MW];
    logic [31:0] m_data  [2][NW];
    logic [31:0] m_tag   [2][NL];
    bit          m_val   [2][NL];
    bit          m_dty   [2][NL];
    bit          m_flag;
    int n_chk = 0, n_fail = 0;
    int rd_beats = 0, wr_beats = 0;

    function automatic logic [31:0] seed_word(input int i);
        return (32'h9E37_79B9 * (i + 1)) ^ (i << 5);
    endfunction

    function automatic logic [3:0] lane_mask(input int off, input int len);
        logic [3:0] m = 4'h0;
        for (int b = 0; b < 4; b++) if (b >= off && b < off + len) m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    assign mem_ready = 1'b1;
    assign mem_rdata = tb_mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MW; i++) tb_mem[i] <= seed_word(i);
        end else if (mem_valid && mem_ready) begin
            if (mem_write) begin
                for (int b = 0; b < 4; b++)
                    if (mem_wstrb[b]) tb_mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                wr_beats <= wr_beats + 1;
            end else begin
                rd_beats <= rd_beats + 1;
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic access(input string ctx, input bit dside, input bit wr, input bit unc,
                          input int len, input logic [31:0] addr, input logic [31:0] wdata,
                          input bit swp, input bit iso);
        int arr, line, widx, mw, lat, exp_lat, exp_rd, exp_wr, r0, w0, tg;
        bit isol, byp, hit;
        logic [3:0] s;
        logic [31:0] exp_data, oldw;
        string tag;
        arr = int'(dside ^ swp);
        isol = dside && iso;
        byp = unc || len > 4;
        line = int'(addr[5:3]);
        widx = int'(addr[5:2]);
        mw = int'(addr[9:2]);
        tg = int'(addr >> 6);
        s = lane_mask(int'(addr[1:0]), len);
        exp_rd = 0; exp_wr = 0; exp_data = 32'h0;
        if (byp) begin
            tag = "R1"; exp_lat = 3;
            if (wr) begin
                exp_wr = 1;
                ref_mem[mw] = merge(ref_mem[mw], wdata, (len > 4) ? 4'hF : s);
            end else begin
                exp_rd = 1; exp_data = ref_mem[mw];
            end
        end else begin
            hit = m_val[arr][line] && (m_tag[arr][line] == tg);
            if (dside && !wr) m_flag = !hit;
            exp_lat = 2;
            if (isol) begin
                tag = "R6";
                if (wr) begin
                    tag = "R10";
                    m_data[arr][widx] = merge(m_data[arr][widx], wdata, s);
                    m_val[arr][line] = 0; m_dty[arr][line] = 0;
                end else exp_data = m_data[arr][widx];
            end else begin
                tag = hit ? (wr ? "R11" : "R4") : "R7";
                if (!hit) begin
                    if (m_val[arr][line] && m_dty[arr][line]) begin
                        tag = "R8"; exp_wr += LW; exp_lat += LW;
                        for (int w = 0; w < LW; w++)
                            ref_mem[(m_tag[arr][line] << 4) + line * LW + w] = m_data[arr][line * LW + w];
                    end
                    for (int w = 0; w < LW; w++)
                        m_data[arr][line * LW + w] = ref_mem[(tg << 4) + line * LW + w];
                    m_tag[arr][line] = tg; m_val[arr][line] = 1; m_dty[arr][line] = 0;
                    exp_rd += LW; exp_lat += LW + 1;
                end
                if (wr) begin
                    oldw = m_data[arr][widx];
                    m_data[arr][widx] = merge(oldw, wdata, s);
                    if (m_data[arr][widx] != oldw) m_dty[arr][line] = 1;
                    ref_mem[mw] = merge(ref_mem[mw], wdata, s);
                    exp_wr += 1; exp_lat += 1;
                end else exp_data = m_data[arr][widx];
            end
        end
        @(negedge clk);
        req_valid = 1; req_data_side = dside; req_write = wr; req_uncached = unc;
        req_len = 3'(len); req_addr = addr; req_wdata = wdata; swap_arrays = swp; isolate_data = iso;
        r0 = rd_beats; w0 = wr_beats;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        chk({ctx, "/R14"}, "stall after accept", {31'h0, stall}, 32'h1);
        while (!resp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk({ctx, "/", tag}, "latency", lat, exp_lat);
        chk({ctx, "/R14"}, "stall at response", {31'h0, stall}, 32'h0);
        chk({ctx, "/", tag}, "read beats", rd_beats - r0, exp_rd);
        chk({ctx, "/", tag}, "write beats", wr_beats - w0, exp_wr);
        chk({ctx, "/R5"}, "miss flag", {31'h0, miss_flag}, {31'h0, m_flag});
        if (!wr) chk({ctx, "/R13"}, "read data", resp_rdata, exp_data);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_data_side = 0; req_write = 0; req_uncached = 0;
        req_len = 0; req_addr = 0; req_wdata = 0; swap_arrays = 0; isolate_data = 0;
        for (int i = 0; i < MW; i++) ref_mem[i] = seed_word(i);
        for (int a = 0; a < 2; a++) begin
            for (int l = 0; l < NL; l++) begin m_val[a][l] = 0; m_dty[a][l] = 0; m_tag[a][l] = 0; end
            for (int w = 0; w < NW; w++) m_data[a][w] = 32'h0;
        end
        m_flag = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: quiet outputs after reset
        chk("R12", "stall", {31'h0, stall}, 32'h0);
        chk("R12", "resp_valid", {31'h0, resp_valid}, 32'h0);
        chk("R12", "miss_flag", {31'h0, miss_flag}, 32'h0);
        chk("R12", "mem_valid", {31'h0, mem_valid}, 32'h0);

        // R3 R4 R7: every word of the data array, miss then hit
        for (int w = 0; w < NW; w++) access("R3", 1, 0, 0, 4, 32'(w * 4), 0, 0, 0);
        for (int w = 0; w < NW; w++) access("R4", 1, 0, 0, 4, 32'(w * 4), 0, 0, 0);

        // R13 R11 R9: every lane pattern on a hit line
        for (int off = 0; off < 4; off++) access("R13", 1, 1, 0, 1, 32'(8 + off), 32'h5A5A5A5A ^ (off << 8), 0, 0);
        for (int off = 0; off < 4; off += 2) access("R13", 1, 1, 0, 2, 32'(16 + off), 32'hC3C3_3C3C, 0, 0);
        access("R11", 1, 1, 0, 4, 32'd20, 32'h1234_5678, 0, 0);
        access("R13", 1, 0, 0, 4, 32'd8, 0, 0, 0);
        // R9: unchanged store leaves the line clean; the conflict then needs no write-back
        access("R9", 1, 1, 0, 4, 32'd0, ref_mem[0], 0, 0);
        access("R9", 1, 0, 0, 4, 32'd64, 0, 0, 0);
        // R8: changed lines are written back on conflict
        for (int l = 1; l < NL; l++) access("R8", 1, 1, 0, 4, 32'(l * 8), 32'hA000_0000 + 32'(l), 0, 0);
        for (int l = 1; l < NL; l++) access("R8", 1, 0, 0, 4, 32'(128 + l * 8), 0, 0, 0);

        // R5: instruction fetches and stores keep the flag
        access("R5", 1, 0, 0, 4, 32'd200, 0, 0, 0);
        access("R5", 0, 0, 0, 4, 32'd300, 0, 0, 0);
        access("R5", 1, 1, 0, 4, 32'd400, 32'h0BAD_F00D, 0, 0);

        // R2: swapped roles
        for (int w = 0; w < NW; w += 2) access("R2", 0, 0, 0, 4, 32'(512 + w * 4), 0, 1, 0);
        for (int w = 0; w < NW; w += 2) access("R2", 1, 0, 0, 4, 32'(512 + w * 4), 0, 0, 0);
        for (int w = 0; w < NW; w += 2) access("R2", 1, 0, 0, 4, 32'(256 + w * 4), 0, 1, 0);
        for (int w = 0; w < NW; w += 2) access("R2", 0, 0, 0, 4, 32'(256 + w * 4), 0, 0, 0);

        // R6 R10: isolation
        for (int w = 0; w < NW; w++) access("R6", 1, 0, 0, 4, 32'(700 + w * 4), 0, 0, 1);
        access("R10", 1, 1, 0, 2, 32'd514, 32'hFACE_0000, 0, 1);
        access("R10", 1, 0, 0, 4, 32'd512, 0, 0, 1);
        access("R10", 1, 0, 0, 4, 32'd512, 0, 0, 0);
        access("R6", 0, 0, 0, 4, 32'd256, 0, 0, 1);

        // R1: bypass by flag and by length
        access("R1", 1, 0, 1, 4, 32'd44, 0, 0, 0);
        access("R1", 1, 1, 1, 1, 32'd45, 32'h0000_EE00, 0, 0);
        for (int len = 5; len < 8; len++) access("R1", 1, 1, 0, len, 32'(100 + len * 4), 32'h7777_0000 + 32'(len), 0, 0);
        access("R1", 1, 0, 0, 6, 32'd104, 0, 0, 1);

        // Mixed sweep
        for (int k = 0; k < 2500; k++) begin
            int sel, len;
            logic [31:0] a;
            sel = $urandom % 3;
            len = (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
            a = 32'($urandom % 512);
            if (len == 2) a[0] = 1'b0;
            if (len == 4) a[1:0] = 2'b00;
            if ($urandom % 16 == 0) len = 5 + $urandom % 3;
            access("MIX", 1'($urandom), 1'($urandom), ($urandom % 12) == 0, len, a,
                   $urandom, ($urandom % 5) == 0, ($urandom % 7) == 0);
        end

        // R11: memory image matches the write-through model
        for (int i = 0; i < MW; i++) chk("R11", "memory image", tb_mem[i], ref_mem[i]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule